// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor

This block adds or subtracts two signed integers held in ones-complement form. Every output is a pure function of the current inputs. No clock or state is involved. When subtraction is selected, the second operand is inverted bit by bit, and that inversion is its negation in this number system. The two values then go through a first ripple addition. The carry that leaves the top bit is not discarded. It is added back in at the least significant bit, the end-around carry, and this gives the final word.

Alongside the result, the block reports two conditions:
- signed overflow, meaning the true result falls outside ±(2^(n−1) − 1);
- zero, for either encoding of zero.

A build-time option can fold the negative-zero pattern (all ones) into positive zero (all zeros) on the result. The word width is a parameter and defaults to 4 bits.

Top module: `ones_comp_addsub`

## Requirements
- R1: With `sub_en` = 0 and no overflow, `sum_out` decoded as ones-complement equals the decoded value of `a_in` plus the decoded value of `b_in`. A word with bit WIDTH−1 set decodes to −(bitwise inverse).
- R2: With `sub_en` = 1 and no overflow, `sum_out` decoded equals decoded `a_in` minus decoded `b_in`. The block forms this as `a_in` plus the bitwise inverse of `b_in`.
- R3: The result word is formed as follows. Let the raw sum be `a_in` plus the effective second operand. If the raw sum reaches 2^WIDTH, the result is the raw sum minus 2^WIDTH plus 1. Otherwise the result is the raw sum unchanged. At width 4, 1011 + 1100 gives 1000, and 0100 − 0011 gives 0001.
- R4: `ovf_out` is 1 exactly when the mathematical result lies outside −(2^(WIDTH−1) − 1) to +(2^(WIDTH−1) − 1). This is the case where both effective operands share a sign bit and the result's sign bit differs from it.
- R5: `zero_out` is 1 when `sum_out` is all zeros or all ones, and 0 for every other value.
- R6: With `FOLD_NEG_ZERO` = 0, a result of all ones is left as it is. For example, x − x gives all ones. With `FOLD_NEG_ZERO` = 1, an all-ones result is replaced by all zeros and `zero_out` stays 1. Overflow is judged on the result before this folding.
- R7: After reset the bench holds both operands at zero with addition selected. `sum_out` is then all zeros, `zero_out` is 1 and `ovf_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand, ones-complement |
| b_in | input | WIDTH | Second operand, ones-complement |
| sub_en | input | 1 | 0 selects a_in + b_in, 1 selects a_in − b_in |
| sum_out | output | WIDTH | Result after end-around carry and optional zero folding |
| ovf_out | output | 1 | Signed overflow |
| zero_out | output | 1 | Result is either encoding of zero |

## Verification
The bench builds two copies of the block:
- The first uses the defaults: width 4, with negative zero kept. Every operand pair in both modes is swept, so every end-around carry case is reached, including the ±7 range edges and the results that come out as negative zero.
- The second uses width 6 with folding enabled, and is also swept in full. It shows that the carry feedback and the overflow rule scale with the parameter, and that folding never leaves the all-ones pattern on the output.

Directed cases from the requirements are checked by name before the sweeps.

// File: rtl/oc_pkg.sv
// Package: shared definitions for the ones-complement adder/subtractor.
// Assumes operands are plain ones-complement words of any width.
package oc_pkg;

    // Operation selected by the add/subtract control.
    typedef enum logic {
        OC_OP_ADD = 1'b0,
        OC_OP_SUB = 1'b1
    } oc_op_e;

endpackage

// File: rtl/oc_operand_prep.sv
// Module: oc_operand_prep
// Forms the effective second operand: passed through for addition,
// bitwise inverted (its ones-complement negation) for subtraction.
// Assumes: op is a settled combinational select.
module oc_operand_prep
    import oc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_raw,
    input  oc_op_e           op,
    output logic [WIDTH-1:0] b_eff
);

    // One conditional inverter per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_eff[i] = b_raw[i] ^ (op == OC_OP_SUB);
    end

endmodule

// File: rtl/oc_ripple_adder.sv
// Module: oc_ripple_adder
// Plain ripple-carry adder built from full-adder cells.
// Assumes: unsigned bit vectors; the carry out is reported, not dropped.
module oc_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);

    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    // Full-adder cell per bit: sum from propagate, carry from generate/propagate.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic prop;
        logic gen;
        assign prop         = x[i] ^ y[i];
        assign gen          = x[i] & y[i];
        assign s[i]         = prop ^ carry[i];
        assign carry[i+1]   = gen | (prop & carry[i]);
    end

    assign cout = carry[WIDTH];

endmodule

// File: rtl/oc_result_flags.sv
// Module: oc_result_flags
// Derives overflow and zero flags and applies the optional folding of
// negative zero into positive zero.
// Assumes: raw_res is the end-around-corrected sum; operand signs are
// those of the first operand and the effective (possibly inverted) second.
module oc_result_flags #(
    parameter int WIDTH         = 4,
    parameter bit FOLD_NEG_ZERO = 1'b0
) (
    input  logic [WIDTH-1:0] raw_res,
    input  logic             sign_x,
    input  logic             sign_y,
    output logic [WIDTH-1:0] res,
    output logic             ovf,
    output logic             zero
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic raw_is_neg_zero;
    logic raw_is_pos_zero;

    // Recognise both zero encodings on the corrected sum.
    assign raw_is_neg_zero = (raw_res == ALL_ONES);
    assign raw_is_pos_zero = (raw_res == '0);

    // Overflow: like-signed operands yielding an unlike-signed result.
    assign ovf = (sign_x == sign_y) && (raw_res[WIDTH-1] != sign_x);

    // Variant chosen by parameter: keep or fold negative zero.
    if (FOLD_NEG_ZERO) begin : g_fold
        assign res = raw_is_neg_zero ? '0 : raw_res;
    end else begin : g_keep
        assign res = raw_res;
    end

    // Zero flag covers either encoding, before or after folding.
    assign zero = raw_is_neg_zero | raw_is_pos_zero;

endmodule

// File: rtl/ones_comp_addsub.sv
// Module: ones_comp_addsub
// Ones-complement adder/subtractor with end-around carry. A first ripple
// pass adds a_in to the effective second operand; its carry out is fed
// into a second pass at bit 0. Flags report overflow and zero.
// Assumes: purely combinational use; inputs are held stable while read.
module ones_comp_addsub
    import oc_pkg::*;
#(
    parameter int WIDTH         = 4,
    parameter bit FOLD_NEG_ZERO = 1'b0
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             ovf_out,
    output logic             zero_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    oc_op_e           op_sel;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] pass1_sum;
    logic             pass1_carry;
    logic [WIDTH-1:0] pass2_sum;
    logic             pass2_carry;

    // Map the control pin onto the operation type.
    assign op_sel = sub_en ? OC_OP_SUB : OC_OP_ADD;

    oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_raw (b_in),
        .op    (op_sel),
        .b_eff (b_eff)
    );

    oc_ripple_adder #(.WIDTH(WIDTH)) u_pass1 (
        .x    (a_in),
        .y    (b_eff),
        .cin  (1'b0),
        .s    (pass1_sum),
        .cout (pass1_carry)
    );

    oc_ripple_adder #(.WIDTH(WIDTH)) u_pass2 (
        .x    (pass1_sum),
        .y    ({WIDTH{1'b0}}),
        .cin  (pass1_carry),
        .s    (pass2_sum),
        .cout (pass2_carry)
    );

    oc_result_flags #(.WIDTH(WIDTH), .FOLD_NEG_ZERO(FOLD_NEG_ZERO)) u_flags (
        .raw_res (pass2_sum),
        .sign_x  (a_in[WIDTH-1]),
        .sign_y  (b_eff[WIDTH-1]),
        .res     (sum_out),
        .ovf     (ovf_out),
        .zero    (zero_out)
    );

    // Cross-checks between the passes, the flags and the ports.
    always_comb begin
        // R3: the fed-back carry can never ripple out a second time.
        assert_no_second_carry_R3: assert (!pass2_carry)
            else $error("second-pass carry out set");
        // R3: without a first-pass carry the second pass leaves the sum alone.
        assert_pass_through_R3: assert (pass1_carry || (pass2_sum == pass1_sum))
            else $error("second pass altered sum with no carry");
        // R4: overflow only arises from like-signed operands.
        assert_ovf_like_signs_R4: assert (!ovf_out || (a_in[WIDTH-1] == b_eff[WIDTH-1]))
            else $error("overflow with unlike-signed operands");
        // R5: the zero flag matches one of the two zero encodings of the result.
        assert_zero_flag_R5: assert (!zero_out || (sum_out == '0) || (sum_out == ALL_ONES))
            else $error("zero flag with non-zero result");
        // R6: when folding is on, negative zero never reaches the port.
        assert_no_neg_zero_R6: assert (!FOLD_NEG_ZERO || (sum_out != ALL_ONES))
            else $error("negative zero on output with folding enabled");
    end

endmodule

// File: tb/test_ones_comp_addsub.sv
`timescale 1ns/1ps
module test_ones_comp_addsub;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    // Default build: width 4, negative zero kept.
    logic [3:0] a4, b4, s4;
    logic       sub4, ovf4, zero4;
    ones_comp_addsub i_ones_comp_addsub (
        .a_in(a4), .b_in(b4), .sub_en(sub4),
        .sum_out(s4), .ovf_out(ovf4), .zero_out(zero4)
    );

    // Second build: width 6, negative zero folded.
    logic [5:0] a6, b6, s6;
    logic       sub6, ovf6, zero6;
    ones_comp_addsub #(.WIDTH(6), .FOLD_NEG_ZERO(1'b1)) i_ones_comp_addsub_w6 (
        .a_in(a6), .b_in(b6), .sub_en(sub6),
        .sum_out(s6), .ovf_out(ovf6), .zero_out(zero6)
    );

    // Decode a ones-complement word to a signed integer.
    function automatic int dec(int x, int w);
        int full = (1 << w) - 1;
        if (x[w-1]) return -(full - x);
        return x;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Full reference check of one operand pair against R1..R6.
    task automatic check_case(int w, bit fold, int a, int b, bit sub, int res, bit ovf, bit zr);
        int full = (1 << w) - 1;
        int bb   = sub ? (full ^ b) : b;
        int raw  = a + bb;
        int want;
        int math;
        bit want_ovf;
        if (raw > full) raw = raw - (full + 1) + 1;            // R3 end-around
        want = (fold && raw == full) ? 0 : raw;                 // R6 folding
        math = sub ? dec(a, w) - dec(b, w) : dec(a, w) + dec(b, w);
        want_ovf = (math > (1 << (w-1)) - 1) || (math < -((1 << (w-1)) - 1));
        check("R3", "result word", res, want);
        check("R4", "overflow", int'(ovf), int'(want_ovf));
        check("R5", "zero flag", int'(zr), int'(res == 0 || res == full));
        if (!want_ovf) begin
            if (sub) check("R2", "difference value", dec(res, w), math);
            else     check("R1", "sum value", dec(res, w), math);
        end
    endtask

    task automatic drive4(int a, int b, bit sub);
        @(posedge clk); #1;
        a4 = 4'(a); b4 = 4'(b); sub4 = sub;
        @(negedge clk);
    endtask

    task automatic drive6(int a, int b, bit sub);
        @(posedge clk); #1;
        a6 = 6'(a); b6 = 6'(b); sub6 = sub;
        @(negedge clk);
    endtask

    // R7: outputs with zero operands held during and after reset.
    task automatic t_reset_state();
        @(negedge clk);
        check("R7", "sum after reset", int'(s4), 0);
        check("R7", "zero after reset", int'(zero4), 1);
        check("R7", "ovf after reset", int'(ovf4), 0);
    endtask

    // R3: worked end-around examples at width 4.
    task automatic t_end_around_examples();
        drive4(4'b1011, 4'b1100, 1'b0);
        check("R3", "-4 + -3", int'(s4), 4'b1000);
        drive4(4'b0100, 4'b0011, 1'b1);
        check("R3", "4 - 3", int'(s4), 4'b0001);
    endtask

    // R4: range edges at width 4.
    task automatic t_overflow_edges();
        drive4(4'b0111, 4'b0001, 1'b0);
        check("R4", "7 + 1 overflows", int'(ovf4), 1);
        drive4(4'b0110, 4'b0001, 1'b0);
        check("R4", "6 + 1 in range", int'(ovf4), 0);
        drive4(4'b1000, 4'b0001, 1'b1);
        check("R4", "-7 - 1 overflows", int'(ovf4), 1);
    endtask

    // R6: x - x gives negative zero kept, or folded at width 6.
    task automatic t_neg_zero();
        drive4(4'b0101, 4'b0101, 1'b1);
        check("R6", "x-x kept as all ones", int'(s4), 4'b1111);
        check("R5", "zero flag on -0", int'(zero4), 1);
        drive6(6'd9, 6'd9, 1'b1);
        check("R6", "x-x folded to zero", int'(s6), 0);
        check("R6", "zero flag after fold", int'(zero6), 1);
    endtask

    task automatic t_sweep4();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int s = 0; s < 2; s++) begin
                    drive4(a, b, s[0]);
                    check_case(4, 1'b0, a, b, s[0], int'(s4), ovf4, zero4);
                end
    endtask

    task automatic t_sweep6();
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int s = 0; s < 2; s++) begin
                    drive6(a, b, s[0]);
                    check_case(6, 1'b1, a, b, s[0], int'(s6), ovf6, zero6);
                end
    endtask

    initial begin
        a4 = '0; b4 = '0; sub4 = 1'b0;
        a6 = '0; b6 = '0; sub6 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_end_around_examples();
        t_overflow_edges();
        t_neg_zero();
        t_sweep4();
        t_sweep6();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule